// File: doc/BRIEF.md
# Ring-Crossing Call/Return Unit

This unit carries out the control transfers of a ring-protected processor that may move execution between protection rings. It handles procedure calls, procedure returns, privileged operations and traps. It holds the instruction pointer (ring, segment, word), a small file of pointer registers, and a save register. For each operation it decides whether the transfer completes in hardware or must go to software.

Neighbouring logic supplies the resolved target segment and word and the effective ring of the reference. It also supplies the target segment's descriptor fields: the bottom and top of the execute bracket, the top of the gate extension, and a flag that says the target word is a gate. Downward calls through gates and upward returns complete in one clock edge. On a call, pointer register 0 is aimed at the stack segment of the new ring. On an upward return, every pointer register's ring is raised to at least the new ring.

Upward calls, downward returns, access violations and privileged operations outside ring 0 become traps. A trap saves the current instruction pointer and jumps to a fixed ring-0 vector. A ring-0 restore operation brings the saved pointer back.

Top module: `ring_xfer_unit`

## Requirements
- R1: A CALL whose target segment differs from the current instruction segment, and whose target word is not flagged as a gate, traps with cause 1 (access violation). A CALL that stays inside the current segment needs no gate.
- R2: A CALL whose effective ring is numerically above the current ring traps with cause 1. This check has the highest priority among call checks. After it come, in order, the upward-call check (R4), the gate-extension limit (effective ring above the extension top traps with cause 1), and the gate check (R1).
- R3: A CALL that is allowed sets the new ring to the effective ring when that ring is at or below the bracket top. When the effective ring lies in the gate extension, the new ring is the bracket top. The instruction pointer takes the target segment and word.
- R4: A CALL whose effective ring is below the execute bracket bottom is an upward call and traps with cause 2.
- R5: A CALL that is allowed loads pointer register 0 with the new ring in its ring field, the new ring number as its segment, and word 0.
- R6: A RETURN whose effective ring is not below the current ring moves the instruction pointer to the effective ring and the target segment and word. A RETURN to a lower ring traps with cause 3.
- R7: On a RETURN that is allowed, each pointer register's ring field becomes the larger of its old value and the new ring. The segment and word fields do not change.
- R8: A trap raises the trap output for one cycle, with its cause, on the same edge that sets the instruction pointer to ring 0 and the fixed vector. The same edge copies the previous instruction pointer into the save register.
- R9: The privileged operations (op 3, PRIV, and op 4, RESTORE) complete only in ring 0, and pulse the grant output when they do. In any other ring they trap with cause 4 and leave the save contents as the trapping pointer.
- R10: RESTORE in ring 0 loads the instruction pointer from the save register.
- R11: After reset, the instruction pointer, every pointer register and the save register are zero. The trap and grant outputs are low.
- Op encoding: 0 none, 1 CALL, 2 RETURN, 3 PRIV, 4 RESTORE. Pointer register k occupies bits [k*W +: W] of each flattened port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Operation code |
| tgt_seg | input | SW | Resolved target segment |
| tgt_word | input | WW | Resolved target word |
| eff_ring | input | RW | Effective ring of the reference |
| br_r1 | input | RW | Execute bracket bottom |
| br_r2 | input | RW | Execute bracket top |
| br_r3 | input | RW | Gate extension top |
| tgt_gate | input | 1 | Target word is a gate |
| ip_ring | output | RW | Current ring of execution |
| ip_seg | output | SW | Instruction segment |
| ip_word | output | WW | Instruction word |
| pr_ring | output | NPR*RW | Pointer register ring fields |
| pr_seg | output | NPR*SW | Pointer register segments |
| pr_word | output | NPR*WW | Pointer register words |
| sv_ring | output | RW | Saved ring |
| sv_seg | output | SW | Saved segment |
| sv_word | output | WW | Saved word |
| trap | output | 1 | Trap taken (one-cycle pulse) |
| trap_cause | output | 3 | Trap cause code |
| priv_grant | output | 1 | Privileged operation completed |

## Verification
A single CALL can meet two violations at the same time. For example, it can enter a foreign segment at a non-gate word while its effective ring is also outside the gate extension or below the bracket bottom. The cause code must then show the higher-priority rule. The bench provokes these collisions by raising several descriptor conditions on one CALL, and judges the cause code against the stated order.

A second overlap is a trap and the save capture, which share one edge. After each trap, the bench checks that the save register holds the pointer from before the trap while the instruction pointer already sits at the vector.

// File: rtl/ring_xfer_unit.sv
module ring_xfer_unit #(
  parameter int RW = 3,
  parameter int SW = 8,
  parameter int WW = 12,
  parameter int NPR = 4,
  parameter int TRAP_SEG = 0,
  parameter int TRAP_WORD = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op,
  input  logic [SW-1:0]      tgt_seg,
  input  logic [WW-1:0]      tgt_word,
  input  logic [RW-1:0]      eff_ring,
  input  logic [RW-1:0]      br_r1,
  input  logic [RW-1:0]      br_r2,
  input  logic [RW-1:0]      br_r3,
  input  logic               tgt_gate,
  output logic [RW-1:0]      ip_ring,
  output logic [SW-1:0]      ip_seg,
  output logic [WW-1:0]      ip_word,
  output logic [NPR*RW-1:0]  pr_ring,
  output logic [NPR*SW-1:0]  pr_seg,
  output logic [NPR*WW-1:0]  pr_word,
  output logic [RW-1:0]      sv_ring,
  output logic [SW-1:0]      sv_seg,
  output logic [WW-1:0]      sv_word,
  output logic               trap,
  output logic [2:0]         trap_cause,
  output logic               priv_grant
);
  localparam logic [2:0] OP_CALL = 3'd1, OP_RET = 3'd2, OP_PRIV = 3'd3, OP_REST = 3'd4;
  localparam logic [2:0] C_NONE = 3'd0, C_ACCV = 3'd1, C_UPCALL = 3'd2, C_DNRET = 3'd3, C_PRIV = 3'd4;

  logic [RW-1:0] prr [NPR];
  logic [SW-1:0] prs [NPR];
  logic [WW-1:0] prw [NPR];

  wire is_call = (op == OP_CALL);
  wire is_ret  = (op == OP_RET);
  wire is_priv = (op == OP_PRIV) || (op == OP_REST);
  wire ring0   = (ip_ring == '0);
  wire [RW-1:0] call_ring = (eff_ring <= br_r2) ? eff_ring : br_r2;

  logic [2:0] cause;
  always_comb begin
    cause = C_NONE;
    if (is_call) begin
      if (eff_ring > ip_ring)                     cause = C_ACCV;
      else if (eff_ring < br_r1)                  cause = C_UPCALL;
      else if (eff_ring > br_r3)                  cause = C_ACCV;
      else if (tgt_seg != ip_seg && !tgt_gate)    cause = C_ACCV;
    end else if (is_ret) begin
      if (eff_ring < ip_ring)                     cause = C_DNRET;
    end else if (is_priv && !ring0) begin
      cause = C_PRIV;
    end
  end
  wire fault = (cause != C_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_ring <= '0; ip_seg <= '0; ip_word <= '0;
      sv_ring <= '0; sv_seg <= '0; sv_word <= '0;
      trap <= 1'b0; trap_cause <= C_NONE; priv_grant <= 1'b0;
      for (int i = 0; i < NPR; i++) begin
        prr[i] <= '0; prs[i] <= '0; prw[i] <= '0;
      end
    end else begin
      trap       <= fault;
      trap_cause <= cause;
      priv_grant <= is_priv && !fault;
      if (fault) begin
        sv_ring <= ip_ring; sv_seg <= ip_seg; sv_word <= ip_word;
        ip_ring <= '0;
        ip_seg  <= SW'(TRAP_SEG);
        ip_word <= WW'(TRAP_WORD);
      end else if (is_call) begin
        ip_ring <= call_ring; ip_seg <= tgt_seg; ip_word <= tgt_word;
        prr[0] <= call_ring;
        prs[0] <= SW'(call_ring);
        prw[0] <= '0;
      end else if (is_ret) begin
        ip_ring <= eff_ring; ip_seg <= tgt_seg; ip_word <= tgt_word;
        for (int i = 0; i < NPR; i++)
          if (prr[i] < eff_ring) prr[i] <= eff_ring;
      end else if (op == OP_REST) begin
        ip_ring <= sv_ring; ip_seg <= sv_seg; ip_word <= sv_word;
      end
    end
  end

  for (genvar g = 0; g < NPR; g++) begin : g_flat
    assign pr_ring[g*RW +: RW] = prr[g];
    assign pr_seg[g*SW +: SW]  = prs[g];
    assign pr_word[g*WW +: WW] = prw[g];
  end
endmodule

// File: rtl/ring_xfer_unit_chk.sv
module ring_xfer_unit_chk #(
  parameter int RW = 3,
  parameter int SW = 8,
  parameter int WW = 12,
  parameter int NPR = 4,
  parameter int TRAP_SEG = 0,
  parameter int TRAP_WORD = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op,
  input logic [RW-1:0]     eff_ring,
  input logic [RW-1:0]     ip_ring,
  input logic [SW-1:0]     ip_seg,
  input logic [WW-1:0]     ip_word,
  input logic [NPR*RW-1:0] pr_ring,
  input logic [NPR*SW-1:0] pr_seg,
  input logic [NPR*WW-1:0] pr_word,
  input logic              trap,
  input logic [2:0]        trap_cause
);
  // R8
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (ip_ring == '0 && ip_seg == SW'(TRAP_SEG) && ip_word == WW'(TRAP_WORD)));
  // R2
  call_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && eff_ring > ip_ring) |=> (trap && trap_cause == 3'd1));
  // R3
  call_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1) |=> (trap || ip_ring <= $past(ip_ring)));
  // R5
  stack_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1) |=> (trap || (pr_ring[RW-1:0] == ip_ring &&
                               pr_seg[SW-1:0] == SW'(ip_ring) && pr_word[WW-1:0] == '0)));
  // R6
  down_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && eff_ring < ip_ring) |=> (trap && trap_cause == 3'd3));
  // R9
  priv_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd3 || op == 3'd4) && ip_ring != '0) |=> (trap && trap_cause == 3'd4));
endmodule

bind ring_xfer_unit ring_xfer_unit_chk #(
  .RW(RW), .SW(SW), .WW(WW), .NPR(NPR), .TRAP_SEG(TRAP_SEG), .TRAP_WORD(TRAP_WORD)
) u_chk (.*);

// File: tb/test_ring_xfer_unit.sv
module test_ring_xfer_unit;
  localparam int RW = 3, SW = 8, WW = 12, NPR = 4;
  localparam int VW = 3+SW+WW+RW*4+1+RW+SW+WW+1+3+RW*2;
  localparam int NV = 17;

  logic clk = 0, rst_n = 0;
  logic [2:0] op = 0;
  logic [SW-1:0] tgt_seg = 0;
  logic [WW-1:0] tgt_word = 0;
  logic [RW-1:0] eff_ring = 0, br_r1 = 0, br_r2 = 0, br_r3 = 0;
  logic tgt_gate = 0;
  logic [RW-1:0] ip_ring, sv_ring;
  logic [SW-1:0] ip_seg, sv_seg;
  logic [WW-1:0] ip_word, sv_word;
  logic [NPR*RW-1:0] pr_ring;
  logic [NPR*SW-1:0] pr_seg;
  logic [NPR*WW-1:0] pr_word;
  logic trap, priv_grant;
  logic [2:0] trap_cause;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ring_xfer_unit #(.RW(RW), .SW(SW), .WW(WW), .NPR(NPR), .TRAP_SEG(0), .TRAP_WORD(64)) i_ring_xfer_unit (.*);

  // op seg word eff r1 r2 r3 gate | ring seg word trap cause pr0 pr1
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd2, 8'd10, 12'd5, 3'd4, 3'd0, 3'd0, 3'd0, 1'b0, 3'd4, 8'd10, 12'd5,  1'b0, 3'd0, 3'd4, 3'd4},
    {3'd1, 8'd20, 12'd3, 3'd4, 3'd1, 3'd2, 3'd5, 1'b1, 3'd2, 8'd20, 12'd3,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd1, 8'd21, 12'd1, 3'd3, 3'd4, 3'd5, 3'd2, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd1, 3'd2, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd2, 8'd20, 12'd3,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd1, 8'd30, 12'd1, 3'd2, 3'd3, 3'd4, 3'd1, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd2, 3'd2, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd2, 8'd20, 12'd3,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd1, 8'd31, 12'd1, 3'd2, 3'd0, 3'd1, 3'd1, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd1, 3'd2, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd2, 8'd20, 12'd3,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd1, 8'd31, 12'd7, 3'd2, 3'd0, 3'd2, 3'd4, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd1, 3'd2, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd2, 8'd20, 12'd3,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd1, 8'd20, 12'd9, 3'd2, 3'd1, 3'd3, 3'd5, 1'b0, 3'd2, 8'd20, 12'd9,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd3, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd4, 3'd2, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd2, 8'd20, 12'd9,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd2, 8'd5,  12'd5, 3'd1, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd3, 3'd2, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd2, 8'd20, 12'd9,  1'b0, 3'd0, 3'd2, 3'd4},
    {3'd2, 8'd11, 12'd2, 3'd3, 3'd0, 3'd0, 3'd0, 1'b0, 3'd3, 8'd11, 12'd2,  1'b0, 3'd0, 3'd3, 3'd4},
    {3'd4, 8'd0,  12'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 8'd0,  12'd64, 1'b1, 3'd4, 3'd3, 3'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o);
    op = o;
    @(posedge clk);
    @(negedge clk);
    op = 3'd0;
  endtask

  task automatic finish_up;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [2:0] vop, vcause;
    logic [SW-1:0] vseg, eseg;
    logic [WW-1:0] vword, eword;
    logic [RW-1:0] veff, vr1, vr2, vr3, ering, epr0, epr1;
    logic vgate, etrap;

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 ip_ring", 32'(ip_ring), 0);
    chk("R11 ip_word", 32'(ip_word), 0);
    chk("R11 pr_ring", 32'(pr_ring), 0);
    chk("R11 sv_word", 32'(sv_word), 0);
    chk("R11 trap", 32'(trap), 0);
    chk("R11 grant", 32'(priv_grant), 0);

    // R9 privileged op in ring 0 completes
    step(3'd3);
    chk("R9 grant ring0", 32'(priv_grant), 1);
    chk("R9 no trap ring0", 32'(trap), 0);

    for (int i = 0; i < NV; i++) begin
      {vop, vseg, vword, veff, vr1, vr2, vr3, vgate, ering, eseg, eword, etrap, vcause, epr0, epr1} = VEC[i];
      tgt_seg = vseg; tgt_word = vword; eff_ring = veff;
      br_r1 = vr1; br_r2 = vr2; br_r3 = vr3; tgt_gate = vgate;
      step(vop);
      // R1 R2 R3 R4 R6 R8 R9 R10 per vector
      chk($sformatf("R3/R6/R10 ring v%0d", i), 32'(ip_ring), 32'(ering));
      chk($sformatf("R3/R6/R10 seg v%0d", i), 32'(ip_seg), 32'(eseg));
      chk($sformatf("R8 word v%0d", i), 32'(ip_word), 32'(eword));
      chk($sformatf("R8 trap v%0d", i), 32'(trap), 32'(etrap));
      chk($sformatf("R1/R2/R4 cause v%0d", i), 32'(trap_cause), 32'(vcause));
      chk($sformatf("R5/R7 pr0 ring v%0d", i), 32'(pr_ring[RW-1:0]), 32'(epr0));
      chk($sformatf("R7 pr1 ring v%0d", i), 32'(pr_ring[2*RW-1:RW]), 32'(epr1));
      if (i == 1) begin
        chk("R5 pr0 seg", 32'(pr_seg[SW-1:0]), 2);
        chk("R5 pr0 word", 32'(pr_word[WW-1:0]), 0);
      end
      if (i == 2) begin
        chk("R8 save ring", 32'(sv_ring), 2);
        chk("R8 save seg", 32'(sv_seg), 20);
        chk("R8 save word", 32'(sv_word), 3);
      end
      if (i == 15) begin
        chk("R7 pr3 ring", 32'(pr_ring[4*RW-1:3*RW]), 4);
        chk("R7 pr1 seg kept", 32'(pr_seg[2*SW-1:SW]), 0);
      end
      if (i == 16) begin
        chk("R9 save ring", 32'(sv_ring), 3);
        chk("R9 save seg", 32'(sv_seg), 11);
      end
    end

    // trap pulse lasts one cycle
    @(negedge clk);
    chk("R8 trap pulse", 32'(trap), 0);

    // R11 reset in mid-run clears pointer registers
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R11 pr_ring after reset", 32'(pr_ring), 0);
    chk("R11 pr_seg after reset", 32'(pr_seg), 0);
    chk("R11 sv_seg after reset", 32'(sv_seg), 0);
    finish_up();
  end
endmodule